// File: doc/BRIEF.md
# Multi-Mode Timer Counter with Update Events

This block is a programmable timer counter. It has three counting modes: up, down and center-aligned. Each time the count wraps in the way the selected mode defines, it raises a one-cycle update event. A one-cycle software strobe or a request from a slave controller forces an update at any time. The forced update also puts the counter back at its starting point for the current direction. A slow time base drives the count-enable tick. A configuration enable gates that tick, so the counter advances only when both are high.

Every configuration input is a level. The inputs are the direction bit, the two-bit center-mode field, the reload value and the counter enable. The software update input is a strobe that acts in each cycle it is high. The block outputs the count, the update event and the current counting direction.

A two-state phase machine holds the direction, with the states PH_UP and PH_DOWN. It has three named transitions:
- T_FOLLOW: when the center-mode field is zero, the next state copies the direction bit.
- T_PEAK: in center mode, PH_UP goes to PH_DOWN when a counter step sees the count at or above the reload value.
- T_TROUGH: in center mode, PH_DOWN goes to PH_UP when a counter step sees the count at zero.

A forced update never moves the state.

Top module: `mode_timer`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the count is 0, the update event is 0 and the direction output is 0.
- R2: In up mode (center field 2'b00, direction bit 0), each step adds one to the count. A step taken when the count is at or above the reload value makes the count 0 and raises the update event.
- R3: In down mode (center field 2'b00, direction bit 1), each step subtracts one from the count. A step taken when the count is 0 loads the reload value and raises the update event.
- R4: In center mode (center field not 2'b00), the count moves in the direction the direction output shows.
  - In the up phase, a step taken at or above the reload value sets the direction output to 1, makes the count reload-1 (0 if the reload is 0) and raises the update event.
  - In the down phase, a step taken at 0 sets the direction output to 0, makes the count 1 (0 if the reload is 0) and raises the update event.
- R5: A high software update strobe raises the update event. It sets the count to 0 if the direction output is 0, or to the reload value if it is 1. This holds whatever the tick and enable inputs are, and it takes priority over a step.
- R6: A high slave update request has exactly the same effect as R5.
- R7: A step happens only in a cycle where both the tick and the counter enable are 1. With no step and no forced update, the count holds and no update event is raised.
- R8: The update event is registered. Each event raises it for exactly the one cycle after the edge that caused it, in the same cycle as the new count.
- R9: When the center field is 2'b00, the direction output equals the direction bit one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter enable |
| tick | input | 1 | Count-enable tick |
| cfg_down | input | 1 | Direction bit, 1 = down (edge modes) |
| cfg_center | input | 2 | Center-mode field, nonzero = center-aligned |
| cfg_reload | input | CNT_W | Reload (period) value |
| sw_update | input | 1 | Software update strobe |
| slv_update | input | 1 | Slave-controller update request |
| count | output | CNT_W | Current count |
| update_evt | output | 1 | One-cycle update event |
| dir_down | output | 1 | Current direction, 1 = counting down |

## Verification
Every result is registered. The count, the update event and the direction output all take their new value one clock edge after the inputs that cause it. The bench drives inputs on the falling edge and steps a reference model with those same inputs. It then waits for the next rising edge and compares the outputs on the falling edge that follows, so each check samples exactly one cycle after its stimulus. For R9, a change of the direction bit is first visible on the output one cycle later. The reference model holds its own copy of the direction, so this delay is accounted for.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        PH_UP   = 1'b0,
        PH_DOWN = 1'b1
    } phase_e;
    localparam int CENTER_W = 2;
endpackage

// File: rtl/tmr_phase_fsm.sv
module tmr_phase_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic center,
    input  logic cfg_down,
    input  logic step,
    input  logic force_upd,
    input  logic at_top,
    input  logic at_bottom,
    output phase_e phase,
    output logic dir_down
);
    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_UP: begin
                if (!center)
                    state_d = cfg_down ? PH_DOWN : PH_UP;      // T_FOLLOW
                else if (step && !force_upd && at_top)
                    state_d = PH_DOWN;                          // T_PEAK
            end
            PH_DOWN: begin
                if (!center)
                    state_d = cfg_down ? PH_DOWN : PH_UP;      // T_FOLLOW
                else if (step && !force_upd && at_bottom)
                    state_d = PH_UP;                            // T_TROUGH
            end
            default: state_d = PH_UP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_UP;
        else        state_q <= state_d;
    end

    always_comb begin
        phase    = state_q;
        dir_down = (state_q == PH_DOWN);
    end

    AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !center |=> (dir_down == $past(cfg_down))); // R9

    AST_FORCE_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (center && force_upd) |=> $stable(dir_down)); // R5
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             center,
    input  logic             cfg_down,
    input  phase_e           phase,
    input  logic [CNT_W-1:0] reload,
    input  logic             step,
    input  logic             force_upd,
    output logic [CNT_W-1:0] count,
    output logic             evt,
    output logic             at_top,
    output logic             at_bottom
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             evt_d;
    logic             going_down;
    logic             wrap;
    logic [CNT_W-1:0] wrap_val;

    assign at_top    = (cnt_q >= reload);
    assign at_bottom = (cnt_q == ZERO);

    always_comb begin
        going_down = center ? (phase == PH_DOWN) : cfg_down;
        wrap       = going_down ? at_bottom : at_top;
        if (!center)
            wrap_val = going_down ? reload : ZERO;
        else if (reload == ZERO)
            wrap_val = ZERO;
        else
            wrap_val = going_down ? ONE : (reload - ONE);
    end

    always_comb begin
        cnt_d = cnt_q;
        evt_d = 1'b0;
        if (force_upd) begin
            cnt_d = (phase == PH_DOWN) ? reload : ZERO;
            evt_d = 1'b1;
        end else if (step) begin
            if (wrap) begin
                cnt_d = wrap_val;
                evt_d = 1'b1;
            end else begin
                cnt_d = going_down ? (cnt_q - ONE) : (cnt_q + ONE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            evt   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            evt   <= evt_d;
        end
    end

    assign count = cnt_q;

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!center && !cfg_down && step && !force_upd && at_top) |=> (count == ZERO && evt)); // R2

    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!center && cfg_down && step && !force_upd && at_bottom) |=> (count == $past(reload) && evt)); // R3

    AST_FORCE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> evt); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !force_upd) |=> (!evt && $stable(count))); // R7
endmodule

// File: rtl/mode_timer.sv
module mode_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_en,
    input  logic                tick,
    input  logic                cfg_down,
    input  logic [CENTER_W-1:0] cfg_center,
    input  logic [CNT_W-1:0]    cfg_reload,
    input  logic                sw_update,
    input  logic                slv_update,
    output logic [CNT_W-1:0]    count,
    output logic                update_evt,
    output logic                dir_down
);
    logic   center, step, force_upd, at_top, at_bottom;
    phase_e phase;

    assign center    = (cfg_center != '0);
    assign step      = tick & cnt_en;
    assign force_upd = sw_update | slv_update;

    tmr_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .center    (center),
        .cfg_down  (cfg_down),
        .step      (step),
        .force_upd (force_upd),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .phase     (phase),
        .dir_down  (dir_down)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .center    (center),
        .cfg_down  (cfg_down),
        .phase     (phase),
        .reload    (cfg_reload),
        .step      (step),
        .force_upd (force_upd),
        .count     (count),
        .evt       (update_evt),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !update_evt && !dir_down)); // R1
endmodule

// File: tb/mode_timer_bench.sv
module mode_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0, tick = 1'b0, cfg_down = 1'b0;
    logic [1:0]   cfg_center = 2'b00;
    logic [W-1:0] cfg_reload = '0;
    logic         sw_update = 1'b0, slv_update = 1'b0;
    logic [W-1:0] count;
    logic         update_evt, dir_down;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_cnt = 0;
    bit m_dir = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_timer #(.CNT_W(W)) u_mode_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick(tick),
        .cfg_down(cfg_down), .cfg_center(cfg_center), .cfg_reload(cfg_reload),
        .sw_update(sw_update), .slv_update(slv_update),
        .count(count), .update_evt(update_evt), .dir_down(dir_down)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, predict, compare on the following negedge
    task automatic step(bit en, bit tk, bit dn, logic [1:0] ctr, int arr, bit sw, bit slv);
        int  n_cnt = m_cnt;
        bit  n_dir = m_dir;
        bit  n_evt = 1'b0;
        bit  cen   = (ctr != 2'b00);
        bit  adv   = en && tk;
        bit  down;
        string tag;
        cnt_en = en; tick = tk; cfg_down = dn; cfg_center = ctr;
        cfg_reload = W'(arr); sw_update = sw; slv_update = slv;
        down = cen ? m_dir : dn;
        if (sw || slv) begin
            tag = sw ? "R5" : "R6";
            n_evt = 1'b1;
            n_cnt = m_dir ? arr : 0;
        end else if (!adv) begin
            tag = "R7";
        end else if (!cen) begin
            tag = dn ? "R3" : "R2";
            if (!dn) begin
                if (m_cnt >= arr) begin n_cnt = 0; n_evt = 1'b1; end
                else n_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin n_cnt = arr; n_evt = 1'b1; end
                else n_cnt = m_cnt - 1;
            end
        end else begin
            tag = "R4";
            if (!down) begin
                if (m_cnt >= arr) begin
                    n_dir = 1'b1; n_evt = 1'b1; n_cnt = (arr == 0) ? 0 : arr - 1;
                end else n_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin
                    n_dir = 1'b0; n_evt = 1'b1; n_cnt = (arr == 0) ? 0 : 1;
                end else n_cnt = m_cnt - 1;
            end
        end
        if (!cen) n_dir = dn;
        @(posedge clk);
        @(negedge clk);
        chk(tag, int'(count), n_cnt);
        chk("R8", int'(update_evt), int'(n_evt));
        chk(cen ? "R4" : "R9", int'(dir_down), int'(n_dir));
        m_cnt = n_cnt;
        m_dir = n_dir;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1", int'(count), 0);
        chk("R1", int'(update_evt), 0);
        chk("R1", int'(dir_down), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(count), 0);
        chk("R1", int'(dir_down), 0);

        // R2: up mode, reload 3, full wrap
        for (int i = 0; i < 9; i++) step(1, 1, 0, 2'b00, 3, 0, 0);
        // R7: tick without enable, enable without tick
        step(0, 1, 0, 2'b00, 3, 0, 0);
        step(1, 0, 0, 2'b00, 3, 0, 0);
        // R9 then R3: switch to down, reload 4
        for (int i = 0; i < 12; i++) step(1, 1, 1, 2'b00, 4, 0, 0);
        // R5: software update while disabled, counting down -> reload
        step(0, 0, 1, 2'b00, 4, 1, 0);
        // R6: slave update in the same cycle as a tick
        step(1, 1, 1, 2'b00, 4, 0, 1);
        // R2 with reload 0: event every step
        for (int i = 0; i < 4; i++) step(1, 1, 0, 2'b00, 0, 0, 0);
        // R4: center mode, reload 5, two full periods
        for (int i = 0; i < 22; i++) step(1, 1, 0, 2'b01, 5, 0, 0);
        // R5 in center down phase
        for (int i = 0; i < 6; i++) step(1, 1, 0, 2'b11, 5, 0, 0);
        step(1, 1, 0, 2'b11, 5, 1, 0);
        // R4 center with reload 0
        for (int i = 0; i < 4; i++) step(1, 1, 0, 2'b10, 0, 0, 0);

        // random phase
        for (int blk = 0; blk < 30; blk++) begin
            bit         dn  = 1'($urandom_range(0, 1));
            logic [1:0] ctr = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            int         arr = int'($urandom_range(0, 9));
            for (int i = 0; i < 100; i++) begin
                bit en  = ($urandom_range(0, 9) != 0);
                bit tk  = ($urandom_range(0, 9) < 7);
                bit sw  = ($urandom_range(0, 29) == 0);
                bit slv = ($urandom_range(0, 29) == 0);
                if ($urandom_range(0, 49) == 0) arr = int'($urandom_range(0, 9));
                step(en, tk, dn, ctr, arr, sw, slv);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule